// File: doc/BRIEF.md
# Graphics-Memory DMA Front End

This block sits on the device side of a system DMA channel and moves data into graphics memory. Software writes a destination address and a byte count, then writes 1 to a control register. The block raises a request toward the DMA channel. For every 32-byte beat the channel hands over, it writes one device-memory word at an internal pointer, steps the pointer by 32 and lowers the remaining count by 32.

When the last beat is accepted, the control register clears itself, the count reads zero, and a one-cycle completion event fires. Software waits on that event. The destination register keeps the value that software programmed. If the event never arrives, software writes 0 to the control register to abort. The request then drops, no event is raised, and the count keeps its residual value. A region register accepts writes but always reads 0.

The control logic is a two-state machine. IDLE leaves for RUN on a start write when the count is non-zero (transition START). RUN returns to IDLE on the final beat (transition FINISH, which raises the event) or on a write of 0 to control (transition ABORT, no event). A start write while the count is zero keeps the machine in IDLE and still raises the event (transition EMPTY_START).

Top module: `gfx_dma_front`

## Requirements
- R1: After reset, the destination, count, control and region registers all read 0, and `chan_req` and `done_evt` are low.
- R2: Outside a transfer, the destination register (offset 0x00) and the count register (offset 0x04) read back exactly the 32-bit values last written.
- R3: The region register (offset 0x84) accepts writes but always reads 0. An unmapped offset also reads 0.
- R4: A write to control (offset 0x08) with bit 0 set, while idle and with a non-zero count, makes `chan_req` high from the next cycle. Control reads 1 while the transfer runs.
- R5: Each cycle with `chan_ack` high while `chan_req` is high produces `dev_wr_en` in the same cycle, with `dev_wr_data` equal to `beat_data`. The first beat's `dev_wr_addr` is the destination with its low 5 bits cleared, and each later beat's address is 32 higher.
- R6: Each accepted beat lowers the count by 32. A final remainder of 32 or less goes to 0.
- R7: In the cycle after the final beat, `done_evt` is high for exactly one cycle, `chan_req` is low, control and count read 0, and the destination reads its programmed value.
- R8: A write to control with bit 0 clear during a transfer lowers `chan_req` from the next cycle and raises no event. The count keeps its residual value, and a beat accepted in the abort cycle is still delivered and counted.
- R9: While a transfer runs, writes to the destination and count registers and further start writes have no effect.
- R10: A start write while the count is 0 raises no request and pulses `done_evt` in the next cycle.
- R11: `chan_ack` while `chan_req` is low causes no device write and leaves the count unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr` (combinational) |
| chan_req | output | 1 | Request toward the DMA channel |
| chan_ack | input | 1 | Channel presents a beat this cycle |
| beat_data | input | 256 | 32-byte beat from the channel |
| dev_wr_en | output | 1 | Device-memory write strobe |
| dev_wr_addr | output | 32 | Device-memory byte address of the beat |
| dev_wr_data | output | 256 | Beat data toward device memory |
| done_evt | output | 1 | One-cycle completion event |

## Verification
The hardest cases to reach are the races at the edges of RUN. One is an abort write that lands in the same cycle as the final beat, so the count reaches zero with no event. Another is a start write that arrives while the count is zero. The stimulus aligns a control write of 0 with an asserted `chan_ack` on a 32-byte transfer. It also sweeps counts of zero to six beats, including partial remainders, under several acknowledge spacings, so that the final beat arrives after different gaps.

// File: rtl/gfx_dma_pkg.sv
package gfx_dma_pkg;
    typedef enum logic [0:0] {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } dma_state_e;

    localparam logic [7:0] OFF_DEST   = 8'h00;
    localparam logic [7:0] OFF_COUNT  = 8'h04;
    localparam logic [7:0] OFF_CTRL   = 8'h08;
    localparam logic [7:0] OFF_REGION = 8'h84;
endpackage

// File: rtl/gfx_dma_fsm.sv
module gfx_dma_fsm
    import gfx_dma_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic start_wr,
    input  logic stop_wr,
    input  logic cnt_zero,
    input  logic last_beat,
    input  logic beat,
    output logic run_o,
    output logic load_o,
    output logic done_evt_o
);
    dma_state_e state_q, state_d;
    logic       done_q;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // transitions: START, EMPTY_START, FINISH, ABORT
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (start_wr && !cnt_zero) state_d = ST_RUN;
            ST_RUN: begin
                if (stop_wr)                 state_d = ST_IDLE;
                else if (beat && last_beat)  state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done_q <= 1'b0;
        end else begin
            unique case (state_q)
                ST_IDLE: done_q <= start_wr && cnt_zero;
                ST_RUN:  done_q <= !stop_wr && beat && last_beat;
                default: done_q <= 1'b0;
            endcase
        end
    end

    assign run_o      = (state_q == ST_RUN);
    assign load_o     = (state_q == ST_IDLE) && start_wr;
    assign done_evt_o = done_q;
endmodule

// File: rtl/gfx_dma_xfer.sv
module gfx_dma_xfer #(
    parameter int REG_W      = 32,
    parameter int BEAT_BYTES = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cnt_wr,
    input  logic [REG_W-1:0] wdata,
    input  logic             ptr_load,
    input  logic [REG_W-1:0] dest,
    input  logic             beat,
    output logic [REG_W-1:0] count_o,
    output logic [REG_W-1:0] ptr_o,
    output logic             last_beat_o,
    output logic             cnt_zero_o
);
    localparam int               ALIGN_W  = $clog2(BEAT_BYTES);
    localparam logic [REG_W-1:0] BEAT_INC = REG_W'(BEAT_BYTES);

    logic [REG_W-1:0] count_q, ptr_q;

    assign last_beat_o = (count_q <= BEAT_INC);
    assign cnt_zero_o  = (count_q == '0);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count_q <= '0;
        end else if (cnt_wr) begin
            count_q <= wdata;
        end else if (beat) begin
            count_q <= last_beat_o ? '0 : count_q - BEAT_INC;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr_q <= '0;
        end else if (ptr_load) begin
            ptr_q <= {dest[REG_W-1:ALIGN_W], {ALIGN_W{1'b0}}};
        end else if (beat) begin
            ptr_q <= ptr_q + BEAT_INC;
        end
    end

    assign count_o = count_q;
    assign ptr_o   = ptr_q;
endmodule

// File: rtl/gfx_dma_front.sv
module gfx_dma_front
    import gfx_dma_pkg::*;
#(
    parameter int REG_W      = 32,
    parameter int BEAT_BYTES = 32,
    parameter int REG_AW     = 8
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    reg_wr,
    input  logic [REG_AW-1:0]       reg_addr,
    input  logic [REG_W-1:0]        reg_wdata,
    output logic [REG_W-1:0]        reg_rdata,
    output logic                    chan_req,
    input  logic                    chan_ack,
    input  logic [BEAT_BYTES*8-1:0] beat_data,
    output logic                    dev_wr_en,
    output logic [REG_W-1:0]        dev_wr_addr,
    output logic [BEAT_BYTES*8-1:0] dev_wr_data,
    output logic                    done_evt
);
    logic             run, load, beat, last_beat, cnt_zero;
    logic             ctrl_wr, start_wr, stop_wr, dest_wr, cnt_wr;
    logic [REG_W-1:0] dest_q, count, ptr;

    assign ctrl_wr  = reg_wr && (reg_addr == REG_AW'(OFF_CTRL));
    assign start_wr = ctrl_wr && reg_wdata[0];
    assign stop_wr  = ctrl_wr && !reg_wdata[0];
    assign dest_wr  = reg_wr && (reg_addr == REG_AW'(OFF_DEST)) && !run;
    assign cnt_wr   = reg_wr && (reg_addr == REG_AW'(OFF_COUNT)) && !run;
    assign beat     = chan_ack && run;

    always_ff @(posedge clk) begin
        if (!rst_n)       dest_q <= '0;
        else if (dest_wr) dest_q <= reg_wdata;
    end

    gfx_dma_fsm fsm_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_wr   (start_wr),
        .stop_wr    (stop_wr),
        .cnt_zero   (cnt_zero),
        .last_beat  (last_beat),
        .beat       (beat),
        .run_o      (run),
        .load_o     (load),
        .done_evt_o (done_evt)
    );

    gfx_dma_xfer #(.REG_W(REG_W), .BEAT_BYTES(BEAT_BYTES)) xfer_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .cnt_wr      (cnt_wr),
        .wdata       (reg_wdata),
        .ptr_load    (load),
        .dest        (dest_q),
        .beat        (beat),
        .count_o     (count),
        .ptr_o       (ptr),
        .last_beat_o (last_beat),
        .cnt_zero_o  (cnt_zero)
    );

    always_comb begin
        reg_rdata = '0;
        if (reg_addr == REG_AW'(OFF_DEST))       reg_rdata = dest_q;
        else if (reg_addr == REG_AW'(OFF_COUNT)) reg_rdata = count;
        else if (reg_addr == REG_AW'(OFF_CTRL))  reg_rdata = REG_W'(run);
    end

    assign chan_req    = run;
    assign dev_wr_en   = beat;
    assign dev_wr_addr = ptr;
    assign dev_wr_data = beat_data;
endmodule

// File: rtl/gfx_dma_front_chk.sv
module gfx_dma_front_chk
    import gfx_dma_pkg::*;
#(
    parameter int REG_W      = 32,
    parameter int BEAT_BYTES = 32,
    parameter int REG_AW     = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              reg_wr,
    input logic [REG_AW-1:0] reg_addr,
    input logic [REG_W-1:0]  reg_wdata,
    input logic              chan_req,
    input logic              dev_wr_en,
    input logic [REG_W-1:0]  dev_wr_addr,
    input logic              done_evt,
    input logic [REG_W-1:0]  dest_q
);
    localparam logic [REG_W-1:0] STEP = REG_W'(BEAT_BYTES);

    // R8
    stop_drops_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (chan_req && reg_wr && reg_addr == REG_AW'(OFF_CTRL) && !reg_wdata[0]) |=> !chan_req);

    // R7
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_evt |=> !done_evt);

    // R7
    done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_evt |-> !chan_req);

    // R11
    no_req_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !chan_req |-> !dev_wr_en);

    // R5
    ptr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dev_wr_en |=> (dev_wr_addr == $past(dev_wr_addr) + STEP));

    // R9
    dest_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (chan_req && reg_wr && reg_addr == REG_AW'(OFF_DEST)) |=> $stable(dest_q));
endmodule

bind gfx_dma_front gfx_dma_front_chk #(
    .REG_W(REG_W), .BEAT_BYTES(BEAT_BYTES), .REG_AW(REG_AW)
) chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .reg_wr      (reg_wr),
    .reg_addr    (reg_addr),
    .reg_wdata   (reg_wdata),
    .chan_req    (chan_req),
    .dev_wr_en   (dev_wr_en),
    .dev_wr_addr (dev_wr_addr),
    .done_evt    (done_evt),
    .dest_q      (dest_q)
);

// File: tb/gfx_dma_front_tb_top.sv
module gfx_dma_front_tb_top;
    localparam logic [7:0] A_DEST = 8'h00, A_CNT = 8'h04, A_CTL = 8'h08, A_REG = 8'h84;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         reg_wr = 1'b0;
    logic [7:0]   reg_addr = '0;
    logic [31:0]  reg_wdata = '0;
    logic [31:0]  reg_rdata;
    logic         chan_req;
    logic         chan_ack = 1'b0;
    logic [255:0] beat_data = '0;
    logic         dev_wr_en;
    logic [31:0]  dev_wr_addr;
    logic [255:0] dev_wr_data;
    logic         done_evt;

    int errs = 0;
    int checks = 0;
    int done_seen = 0;

    always #5 clk = ~clk;

    gfx_dma_front dut_i (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .chan_req(chan_req),
        .chan_ack(chan_ack), .beat_data(beat_data), .dev_wr_en(dev_wr_en),
        .dev_wr_addr(dev_wr_addr), .dev_wr_data(dev_wr_data), .done_evt(done_evt)
    );

    always @(negedge clk) if (rst_n && done_evt) done_seen++;

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errs++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic reg_write(logic [7:0] a, logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic read_chk(string tag, logic [7:0] a, logic [31:0] exp);
        reg_addr = a;
        #1;
        check(tag, reg_rdata, exp);
    endtask

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", errs, checks);
    endtask

    task automatic run_xfer(logic [31:0] cnt, logic [31:0] dst, int pat);
        logic [31:0] rem, ea;
        int cyc, d0;
        reg_write(A_CNT, cnt);
        reg_write(A_DEST, dst);
        reg_write(A_REG, 32'hFFFF_FFFF);
        read_chk("R2 dest readback", A_DEST, dst);
        read_chk("R2 count readback", A_CNT, cnt);
        read_chk("R3 region reads zero", A_REG, 32'h0);
        d0 = done_seen;
        reg_write(A_CTL, 32'h1);
        if (cnt == 0) begin
            #1;
            check("R10 empty start event", {31'b0, done_evt}, 32'h1);
            check("R10 empty start no req", {31'b0, chan_req}, 32'h0);
            @(negedge clk);
            #1;
            check("R10 event one cycle", {31'b0, done_evt}, 32'h0);
            return;
        end
        read_chk("R4 ctrl reads one", A_CTL, 32'h1);
        check("R4 request up", {31'b0, chan_req}, 32'h1);
        rem = cnt;
        ea = {dst[31:5], 5'b0};
        cyc = 0;
        while (rem != 0) begin
            chan_ack = ((cyc % pat) == 0);
            beat_data = {8{ea ^ 32'hA5A5_0000}};
            reg_addr = A_CNT;
            #1;
            check("R6 count per beat", reg_rdata, rem);
            check("R7 no early event", {31'b0, done_evt}, 32'h0);
            check("R5 write strobe", {31'b0, dev_wr_en}, {31'b0, chan_ack});
            if (chan_ack) begin
                check("R5 beat address", dev_wr_addr, ea);
                check("R5 beat data", dev_wr_data[31:0], ea ^ 32'hA5A5_0000);
            end
            @(negedge clk);
            if (chan_ack) begin
                rem = (rem > 32) ? rem - 32 : 32'h0;
                ea = ea + 32;
            end
            chan_ack = 1'b0;
            cyc++;
        end
        #1;
        check("R7 event pulse", {31'b0, done_evt}, 32'h1);
        check("R7 request low", {31'b0, chan_req}, 32'h0);
        read_chk("R7 ctrl cleared", A_CTL, 32'h0);
        read_chk("R7 count zero", A_CNT, 32'h0);
        read_chk("R7 dest kept", A_DEST, dst);
        read_chk("R3 region zero after", A_REG, 32'h0);
        @(negedge clk);
        #1;
        check("R7 event single", {31'b0, done_evt}, 32'h0);
        check("R7 one event per transfer", done_seen - d0, 1);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errs++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
        $finish;
    end

    initial begin
        int d0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        read_chk("R1 dest reset", A_DEST, 0);
        read_chk("R1 count reset", A_CNT, 0);
        read_chk("R1 ctrl reset", A_CTL, 0);
        read_chk("R1 region reset", A_REG, 0);
        check("R1 req reset", {31'b0, chan_req}, 0);
        check("R1 event reset", {31'b0, done_evt}, 0);
        read_chk("R3 unmapped reads zero", 8'h40, 0);

        // R11 ack while idle
        reg_write(A_CNT, 32'd64);
        chan_ack = 1'b1;
        #1;
        check("R11 no write when idle", {31'b0, dev_wr_en}, 0);
        @(negedge clk);
        chan_ack = 1'b0;
        read_chk("R11 count unchanged", A_CNT, 32'd64);

        // sweep of counts, alignments and ack spacings
        for (int b = 0; b <= 6; b++) begin
            for (int p = 1; p <= 3; p++) begin
                run_xfer(32'(b * 32), 32'h1000_0000 + 32'(b * 256), p);
                if (b > 0) run_xfer(32'(b * 32 - 7), 32'h0ABC_DE17 + 32'(p * 64), p);
            end
        end

        // R8 abort mid transfer
        d0 = done_seen;
        reg_write(A_CNT, 32'd256);
        reg_write(A_DEST, 32'h2000_0000);
        reg_write(A_CTL, 32'h1);
        chan_ack = 1'b1;
        @(negedge clk);
        @(negedge clk);
        chan_ack = 1'b0;
        reg_write(A_CTL, 32'h0);
        #1;
        check("R8 request dropped", {31'b0, chan_req}, 0);
        read_chk("R8 residual count", A_CNT, 32'd192);
        read_chk("R8 ctrl zero", A_CTL, 0);
        read_chk("R8 dest kept", A_DEST, 32'h2000_0000);
        repeat (5) @(negedge clk);
        check("R8 no event on abort", done_seen - d0, 0);

        // R8 abort in same cycle as final beat
        d0 = done_seen;
        reg_write(A_CNT, 32'd32);
        reg_write(A_CTL, 32'h1);
        reg_wr = 1'b1; reg_addr = A_CTL; reg_wdata = 32'h0; chan_ack = 1'b1;
        #1;
        check("R8 beat in abort cycle", {31'b0, dev_wr_en}, 1);
        @(negedge clk);
        reg_wr = 1'b0; chan_ack = 1'b0;
        #1;
        check("R8 request dropped same cycle", {31'b0, chan_req}, 0);
        read_chk("R8 beat counted", A_CNT, 0);
        repeat (4) @(negedge clk);
        check("R8 no event with final beat", done_seen - d0, 0);

        // R9 writes ignored while running
        d0 = done_seen;
        reg_write(A_CNT, 32'd96);
        reg_write(A_DEST, 32'h3000_0040);
        reg_write(A_CTL, 32'h1);
        reg_write(A_DEST, 32'hDEAD_0000);
        reg_write(A_CNT, 32'd5);
        reg_write(A_CTL, 32'h1);
        read_chk("R9 dest held", A_DEST, 32'h3000_0040);
        read_chk("R9 count held", A_CNT, 32'd96);
        check("R9 still running", {31'b0, chan_req}, 1);
        chan_ack = 1'b1;
        #1;
        check("R9 first address", dev_wr_addr, 32'h3000_0040);
        repeat (3) @(negedge clk);
        chan_ack = 1'b0;
        #1;
        check("R9 completes", {31'b0, done_evt}, 1);
        read_chk("R9 dest after", A_DEST, 32'h3000_0040);
        @(negedge clk);
        check("R9 one event", done_seen - d0, 1);

        summary();
        $finish;
    end
endmodule